// File: doc/BRIEF.md
# Outstanding Write Hazard Tracker

This block sits beside the memory-side request path of a last-level cache. Each write-back that reaches the memory port is logged in a small associative store, from the cycle its address is issued until its acknowledgement comes back. Each log entry is the AXI write ID plus a 16-bit digest of the 64-byte line address. A read is held back while any logged write covers a line with the same digest, so a read can never overtake a write-back to the same line. A new write is held back while the ID that the internal ID counter offers is still in the log. This keeps IDs unique among in-flight writes and lets the fabric reorder responses.

The requester presents a read's address on the read-check port and proceeds only while `rd_allow` is high. A write is issued with a one-cycle strobe on `wr_valid` while `wr_ready` is high, and it carries the ID shown on `wr_id`. Every write response is reported on `rsp_valid` with its BID, whatever its response code. A response with an unknown ID is dropped and latched as an error.

Top module: `wr_hazard_tracker`

## Requirements
- R1: After reset the store is empty: `rd_allow`=1, `wr_ready`=1, `wr_id`=0, `full`=0, `pend_cnt`=0, `orphan_err`=0.
- R2: `rd_allow` is 0 while a valid entry holds the same digest as the read's address, so any two byte addresses inside one 64-byte line conflict. The digest is an XOR fold: digest bit j is the XOR of every address bit i (6 ≤ i ≤ 63) with (i−6) mod 16 = j.
- R3: `rd_allow` is 1 when no valid entry's digest matches, for example for the next line. Two different lines with equal digests conflict (a false stall).
- R4: A write is accepted in a cycle where `wr_valid` and `wr_ready` are both 1. Acceptance logs (`wr_id`, digest of `wr_addr`), and `wr_id` then steps by one modulo 2^ID_W.
- R5: `wr_ready` is 0 while the current `wr_id` is held by a valid entry, even when the store is not full.
- R6: `full` is 1 exactly when all DEPTH entries are valid. While it is 1, `wr_ready` is 0 and `wr_valid` logs nothing.
- R7: A response whose `rsp_bid` equals a valid entry's ID frees that entry in the next cycle.
- R8: `pend_cnt` equals the number of valid entries. It rises by one on each accepted write, falls by one on each matched response, and never exceeds DEPTH.
- R9: An accepted write and a matched response in the same cycle both take effect. Every check in that cycle (read match, ID match, full) sees the entries as they stood at the start of the cycle, so a read of the line being written in that cycle is still allowed.
- R10: A response whose BID matches no valid entry leaves all entries and `pend_cnt` unchanged and sets `orphan_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 64 | Byte address of the read being checked |
| rd_allow | output | 1 | Read may proceed (no digest match) |
| wr_valid | input | 1 | Write address issue request |
| wr_addr | input | 64 | Byte address of the write-back |
| wr_ready | output | 1 | Write may issue this cycle with `wr_id` |
| wr_id | output | ID_W | ID the next accepted write will carry |
| rsp_valid | input | 1 | A write response arrives |
| rsp_bid | input | ID_W | ID carried by the write response |
| full | output | 1 | All entries valid |
| pend_cnt | output | $clog2(DEPTH+1) | Number of writes awaiting a response |
| orphan_err | output | 1 | Sticky: a response named no pending write |

## Verification
On every cycle, the assertions check the following. The response counter agrees with the entry occupancy. A full store never offers a write slot. No two live entries share an ID. A logged write blocks a read of its line in the next cycle. An accepted write moves the ID by one. An orphan response leaves the count alone, and the error flag never drops. Some behaviour only the directed scenarios can show. These are the exact fold (a chosen colliding pair and a neighbouring line), the ID wrapping round onto a still-pending write, and the start-of-cycle view when a write and a response share a cycle.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_ADDR_W   = 64;
  localparam int WT_HASH_W   = 16;
  localparam int WT_LINE_LSB = 6;

  // XOR fold of the line-address bits into the digest width
  function automatic logic [WT_HASH_W-1:0] wt_line_hash(input logic [WT_ADDR_W-1:0] a);
    logic [WT_HASH_W-1:0] h;
    h = '0;
    for (int i = WT_LINE_LSB; i < WT_ADDR_W; i++) begin
      h[(i - WT_LINE_LSB) % WT_HASH_W] = h[(i - WT_LINE_LSB) % WT_HASH_W] ^ a[i];
    end
    return h;
  endfunction
endpackage

// File: rtl/wt_id_gen.sv
module wt_id_gen #(
  parameter int ID_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [ID_W-1:0] id
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    id_q <= '0;
    else if (step) id_q <= id_q + 1'b1;
  end

  assign id = id_q;

  // R4: each accepted write advances the offered ID by one
  p_id_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> id == ID_W'($past(id) + 1'b1));
  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(id));
endmodule

// File: rtl/wt_pend_ctr.sv
module wt_pend_ctr #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (inc && !dec)   cnt_q <= cnt_q + 1'b1;
    else if (dec && !inc)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt = cnt_q;

  // R8: count stays inside 0..DEPTH
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !(dec && !inc));
endmodule

// File: rtl/wt_entry_store.sv
module wt_entry_store #(
  parameter int DEPTH  = 16,
  parameter int ID_W   = 6,
  parameter int HASH_W = 16,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins,
  input  logic [ID_W-1:0]   ins_id,
  input  logic [HASH_W-1:0] ins_hash,
  input  logic              rm,
  input  logic [ID_W-1:0]   rm_id,
  input  logic [HASH_W-1:0] rd_hash,
  input  logic [ID_W-1:0]   cand_id,
  output logic              rd_hit,
  output logic              cand_hit,
  output logic              rm_hit,
  output logic              full,
  output logic [DEPTH-1:0]  slot_valid
);
  logic [DEPTH-1:0]  valid_q;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [HASH_W-1:0] hash_q [DEPTH];

  logic [DEPTH-1:0]  rd_m, cand_m, rm_m;
  logic [SLOT_W-1:0] ins_slot, rm_slot;
  logic              ins_ok, rm_ok;

  function automatic logic [SLOT_W-1:0] lowest_set(input logic [DEPTH-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction

  // per-slot comparators, all against start-of-cycle contents
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign rd_m[g]   = valid_q[g] && (hash_q[g] == rd_hash);
    assign cand_m[g] = valid_q[g] && (id_q[g] == cand_id);
    assign rm_m[g]   = valid_q[g] && (id_q[g] == rm_id);
  end

  assign rd_hit     = |rd_m;
  assign cand_hit   = |cand_m;
  assign rm_hit     = |rm_m;
  assign full       = &valid_q;
  assign slot_valid = valid_q;

  assign ins_slot = lowest_set(~valid_q);
  assign rm_slot  = lowest_set(rm_m);
  assign ins_ok   = ins && !full;
  assign rm_ok    = rm && rm_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rm_ok && (rm_slot == SLOT_W'(i))) valid_q[i] <= 1'b0;
        if (ins_ok && (ins_slot == SLOT_W'(i))) begin
          valid_q[i] <= 1'b1;
          id_q[i]    <= ins_id;
          hash_q[i]  <= ins_hash;
        end
      end
    end
  end

  // R5: live IDs are unique, so a response names at most one entry
  p_id_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rm_m) <= 1);
  // R2: a logged write blocks a read of the same digest one cycle later
  p_insert_blocks_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> (rd_hash != $past(ins_hash)) || rd_hit);
  // R9: a simultaneous insert and removal leave occupancy unchanged
  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ok && rm_ok) |=> $countones(valid_q) == $past($countones(valid_q)));
  // R7: a matched response frees an entry
  p_remove_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_ok && !ins_ok) |=> $countones(valid_q) == $past($countones(valid_q)) - 1);
endmodule

// File: rtl/wr_hazard_tracker.sv
module wr_hazard_tracker #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 6,
  localparam int ADDR_W = wt_pkg::WT_ADDR_W,
  localparam int HASH_W = wt_pkg::WT_HASH_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_allow,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ready,
  output logic [ID_W-1:0]   wr_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_bid,
  output logic              full,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              orphan_err
);
  import wt_pkg::*;

  logic [HASH_W-1:0] rd_hash, wr_hash;
  logic              rd_hit, cand_hit, rm_hit;
  logic [DEPTH-1:0]  slot_valid;
  logic              wr_fire, rsp_match, rsp_orphan;
  logic              err_q;

  assign rd_hash = wt_line_hash(rd_addr);
  assign wr_hash = wt_line_hash(wr_addr);

  wt_id_gen #(.ID_W(ID_W)) u_id (
    .clk(clk), .rst_n(rst_n), .step(wr_fire), .id(wr_id)
  );

  wt_entry_store #(.DEPTH(DEPTH), .ID_W(ID_W), .HASH_W(HASH_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins(wr_fire), .ins_id(wr_id), .ins_hash(wr_hash),
    .rm(rsp_valid), .rm_id(rsp_bid),
    .rd_hash(rd_hash), .cand_id(wr_id),
    .rd_hit(rd_hit), .cand_hit(cand_hit), .rm_hit(rm_hit),
    .full(full), .slot_valid(slot_valid)
  );

  assign wr_ready   = !full && !cand_hit;
  assign wr_fire    = wr_valid && wr_ready;
  assign rsp_match  = rsp_valid && rm_hit;
  assign rsp_orphan = rsp_valid && !rm_hit;
  assign rd_allow   = !rd_hit;

  wt_pend_ctr #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(wr_fire), .dec(rsp_match), .cnt(pend_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (rsp_orphan) err_q <= 1'b1;
  end
  assign orphan_err = err_q;

  // R6: no write slot offered when the store is full
  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);
  // R8: counter and occupancy agree
  p_cnt_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt == CNT_W'($countones(slot_valid)));
  // R10: orphan responses change nothing, the flag is sticky
  p_orphan_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_orphan && !wr_fire) |=> pend_cnt == $past(pend_cnt));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_err |=> orphan_err);
  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_orphan |=> orphan_err);
endmodule

// File: tb/tb_wr_hazard_tracker.sv
module tb_wr_hazard_tracker;
  localparam int DEPTH = 16;
  localparam int ID_W  = 6;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] rd_addr = '0;
  logic rd_allow;
  logic wr_valid = 1'b0;
  logic [63:0] wr_addr = '0;
  logic wr_ready;
  logic [ID_W-1:0] wr_id;
  logic rsp_valid = 1'b0;
  logic [ID_W-1:0] rsp_bid = '0;
  logic full;
  logic [CNT_W-1:0] pend_cnt;
  logic orphan_err;

  int n_vec = 0;
  int n_bad = 0;
  logic [ID_W-1:0] exp_id = '0;
  logic [ID_W-1:0] ids [DEPTH];

  always #2 clk = ~clk;

  wr_hazard_tracker #(.DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_allow(rd_allow),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_ready(wr_ready), .wr_id(wr_id),
    .rsp_valid(rsp_valid), .rsp_bid(rsp_bid), .full(full),
    .pend_cnt(pend_cnt), .orphan_err(orphan_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [63:0] a, input logic exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1 chk(req, 64'(rd_allow), 64'(exp));
  endtask

  task automatic issue(input logic [63:0] a, output logic [ID_W-1:0] id_used);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    #1;
    chk("R4 ready", 64'(wr_ready), 64'd1);
    chk("R4 id", 64'(wr_id), 64'(exp_id));
    id_used = wr_id;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    exp_id = exp_id + 1'b1;
  endtask

  task automatic respond(input logic [ID_W-1:0] b);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_bid   = b;
    @(posedge clk);
    #1 rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    chk("R1 rd_allow", 64'(rd_allow), 64'd1);
    chk("R1 wr_ready", 64'(wr_ready), 64'd1);
    chk("R1 wr_id", 64'(wr_id), 64'd0);
    chk("R1 full", 64'(full), 64'd0);
    chk("R1 cnt", 64'(pend_cnt), 64'd0);
    chk("R1 err", 64'(orphan_err), 64'd0);
  endtask

  task automatic t_hazard;
    logic [63:0] a, coll;
    logic [ID_W-1:0] k;
    a    = 64'h0000_1234_5678_9A00;
    coll = a ^ (64'h1 << 6) ^ (64'h1 << 22);   // line bits 0 and 16 fold together
    issue(a, k);
    read_chk(a + 64'h3F, 1'b0, "R2 same line");
    read_chk(a, 1'b0, "R2 line base");
    read_chk(a + 64'h40, 1'b1, "R3 next line");
    read_chk(coll, 1'b0, "R3 collision stall");
    chk("R8 cnt one", 64'(pend_cnt), 64'd1);
    respond(k);
    read_chk(a, 1'b1, "R7 freed");
    chk("R8 cnt zero", 64'(pend_cnt), 64'd0);
  endtask

  task automatic t_id_step;
    logic [ID_W-1:0] k;
    for (int i = 0; i < 3; i++) begin
      issue(64'h8000 + 64'(i) * 64'h40, k);
      respond(k);
    end
    @(negedge clk);
    #1 chk("R4 id after three", 64'(wr_id), 64'(exp_id));
  endtask

  task automatic t_full_and_overlap;
    logic [63:0] base, fresh;
    logic [ID_W-1:0] k;
    base  = 64'h10_0000;
    fresh = 64'h77_0000;
    for (int i = 0; i < DEPTH; i++) issue(base + 64'(i) * 64'h40, ids[i]);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = fresh;
    #1;
    chk("R6 full", 64'(full), 64'd1);
    chk("R6 ready low", 64'(wr_ready), 64'd0);
    chk("R8 cnt depth", 64'(pend_cnt), 64'(DEPTH));
    @(posedge clk);
    #1 wr_valid = 1'b0;
    read_chk(fresh, 1'b1, "R6 no log when full");
    chk("R6 cnt held", 64'(pend_cnt), 64'(DEPTH));
    respond(ids[0]);
    chk("R6 not full", 64'(full), 64'd0);
    // R9: issue and matched response in one cycle
    @(negedge clk);
    wr_valid  = 1'b1;
    wr_addr   = fresh;
    rsp_valid = 1'b1;
    rsp_bid   = ids[1];
    rd_addr   = fresh;
    #1;
    chk("R9 ready", 64'(wr_ready), 64'd1);
    chk("R9 read of same-cycle write", 64'(rd_allow), 64'd1);
    k = wr_id;
    @(posedge clk);
    #1;
    wr_valid  = 1'b0;
    rsp_valid = 1'b0;
    exp_id    = exp_id + 1'b1;
    chk("R9 cnt", 64'(pend_cnt), 64'(DEPTH - 1));
    read_chk(fresh, 1'b0, "R9 new write logged");
    read_chk(base + 64'h40, 1'b1, "R9 old write freed");
    for (int i = 2; i < DEPTH; i++) respond(ids[i]);
    respond(k);
    chk("R8 drained", 64'(pend_cnt), 64'd0);
  endtask

  task automatic t_reuse_orphan;
    logic [63:0] h;
    logic [ID_W-1:0] held, k;
    h = 64'hABC0_0000;
    issue(h, held);
    for (int i = 0; i < (1 << ID_W) - 1; i++) begin
      issue(64'h20_0000 + 64'(i) * 64'h40, k);
      respond(k);
    end
    @(negedge clk);
    #1;
    chk("R5 id wrapped", 64'(wr_id), 64'(held));
    chk("R5 ready low", 64'(wr_ready), 64'd0);
    chk("R5 not full", 64'(full), 64'd0);
    respond(held + 1'b1);                       // R10 orphan
    chk("R10 err set", 64'(orphan_err), 64'd1);
    chk("R10 cnt kept", 64'(pend_cnt), 64'd1);
    read_chk(h, 1'b0, "R10 entry kept");
    respond(held);
    #1;
    chk("R5 ready back", 64'(wr_ready), 64'd1);
    chk("R10 err sticky", 64'(orphan_err), 64'd1);
    read_chk(h, 1'b1, "R7 held freed");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_hazard;
    t_id_step;
    t_full_and_overlap;
    t_reuse_orphan;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule